// File: doc/BRIEF.md
# Input Capture Timer Channel

This block is one channel of a general-purpose timer set up for input capture. A free-running counter advances on edges of one of eight level-type clock sources that are sampled in the system clock domain. The counter can be gated by one of three external enable levels. Chosen edges of a monitored input are used to snapshot the running count, first into capture slot A and then into capture slot B. The edges can be thinned out by a subsampling ratio. After slot B loads, the counter can be frozen until the next trigger or switched off entirely. This makes the block suitable for period, pulse-width and duty-cycle measurement.

Software drives the channel through a small word-addressed register port. It issues enable, disable and trigger commands, programs a mode word and a top value, and reads back the count, the two capture slots and a status word whose event flags clear on read. An interrupt line is raised while any event flag selected by the interrupt mask is set. Triggers come from software or from a selectable edge on either the monitored input or a dedicated trigger input.

Top module: `tcap_channel`

## Requirements
- R1: After a synchronous reset, the count, top value, mode word, both capture slots, all event flags and the interrupt mask read as zero, the channel is stopped (status bit 8 low) and `irq` is low.
- R2: While running, the count rises by one on every qualified tick. A tick is a rising edge of `clk_src[sel]`, where sel is mode bits [2:0], or a falling edge when mode bit 3 is set. When mode bits [5:4] hold g≠0, a tick counts only while `clk_src[4+g]` is high. With no tick, or while not running, the count holds.
- R3: A write to address 0 enables the counter with bit 0, disables it with bit 1 and issues a software trigger with bit 2. When bits 0 and 1 are written together, the channel ends up disabled.
- R4: A trigger clears any freeze and arms a reset, so the next tick loads 0 instead of incrementing. An external trigger is an edge, selected by mode bits [16:15], of `in_a` (mode bit 17 = 0) or of `trig_in` (mode bit 17 = 1). It also sets flag bit 5. Every edge-select field in the mode word uses the code 0 none, 1 rising, 2 falling, 3 both.
- R5: An increment from the all-ones count wraps to 0 and sets flag bit 0.
- R6: A tick taken while the count equals the top value (address 5) sets flag bit 2. If mode bit 18 is set, that tick loads 0 instead of incrementing.
- R7: While running, a qualifying edge of `in_a` copies the current count into slot A (address 2) and sets flag bit 3. Slot-A edges are chosen by mode bits [7:6]. The next qualifying edge, chosen by mode bits [9:8], fills slot B (address 3) and sets flag bit 4. The sequence then returns to slot A. When the slot-B field is 0, every load goes to slot A. A trigger restarts the sequence at slot A.
- R8: Mode bits [12:10] hold code c. A load happens on every 2^c-th qualifying edge for c from 0 to 4, and on every 16th edge for codes 5 to 7.
- R9: Loading a slot that has not been read since its previous load sets flag bit 1.
- R10: With mode bit 13 set, a slot-B load freezes the counter until the next trigger. With mode bit 14 set, a slot-B load clears the enable, which only a new enable command restores.
- R11: Reading address 6 returns the event flags in bits [5:0], the running state in bit 8, the sampled `in_a` in bit 9 and the sampled `trig_in` in bit 10. The read clears the event flags. An event that occurs in the cycle of the read stays set. Bits 8 to 10 are not cleared by the read.
- R12: Writing address 7 sets mask bits and writing address 8 clears them. Address 9 reads the mask. `irq` is high exactly when some event flag and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects apply at the clock edge) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| clk_src | input | 8 | Counting clock sources; bits 7..5 also serve as gate levels |
| in_a | input | 1 | Monitored capture input |
| trig_in | input | 1 | External trigger input |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench runs a behavioural model alongside the channel and compares the interrupt line and every read on each cycle. The count is read continuously, so any drift in tick qualification, gating, wrap or top restart shows up in the cycle it happens. Capture is exercised with isolated pulses on the monitored input under rising/falling slot pairs, a slot-A-only setting and several subsampling codes. Together these separate a wrong slot order, an off-by-one edge count and a missing overrun. Freeze and disable after slot B are told apart by whether a trigger alone resumes counting.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int NSRC      = 8;
    localparam int GATE_BASE = 5;
    localparam int MODE_W    = 19;
    localparam int NFLAG     = 6;

    localparam int F_OVF  = 0;
    localparam int F_LOVR = 1;
    localparam int F_CMP  = 2;
    localparam int F_LDA  = 3;
    localparam int F_LDB  = 4;
    localparam int F_ETRG = 5;

    localparam int ST_RUN   = 8;
    localparam int ST_MIRA  = 9;
    localparam int ST_MIRT  = 10;

    typedef enum logic [3:0] {
        A_CMD   = 4'd0,
        A_MODE  = 4'd1,
        A_CAPA  = 4'd2,
        A_CAPB  = 4'd3,
        A_CNT   = 4'd4,
        A_TOP   = 4'd5,
        A_STAT  = 4'd6,
        A_IEN   = 4'd7,
        A_IDIS  = 4'd8,
        A_IMASK = 4'd9
    } addr_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_e;

    typedef struct packed {
        logic       top_rst;
        logic       trig_src;
        edge_e      trig_edge;
        logic       dis_b;
        logic       stop_b;
        logic [2:0] subs;
        edge_e      ldb_edge;
        edge_e      lda_edge;
        logic [1:0] gate_sel;
        logic       clk_inv;
        logic [2:0] clk_sel;
    } mode_t;

    function automatic logic edge_hit(edge_e sel, logic rise, logic fall);
        case (sel)
            EDG_RISE: return rise;
            EDG_FALL: return fall;
            EDG_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] sub_term(logic [2:0] code);
        if (code >= 3'd4) return 4'd15;
        return 4'((5'd1 << code) - 5'd1);
    endfunction

endpackage

// File: rtl/tcap_tick.sv
module tcap_tick
    import tcap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic [2:0]      csel,
    input  logic            inv,
    input  logic [1:0]      gate_sel,
    output logic            tick
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] edg;
    logic [2:0]      gidx;
    logic            gate_ok;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src;
    end

    assign edg     = inv ? (~src & src_q) : (src & ~src_q);
    assign gidx    = 3'(GATE_BASE - 1) + {1'b0, gate_sel};
    assign gate_ok = (gate_sel == 2'd0) ? 1'b1 : src[gidx];
    assign tick    = edg[csel] & gate_ok;

endmodule

// File: rtl/tcap_edge.sv
module tcap_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst) lvl <= '0;
        else     lvl <= sig;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise[g] = sig[g] & ~lvl[g];
        assign fall[g] = ~sig[g] & lvl[g];
    end

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             trig,
    input  logic             a_rise,
    input  logic             a_fall,
    input  edge_e            lda_edge,
    input  edge_e            ldb_edge,
    input  logic [2:0]       subs,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rd_a,
    input  logic             rd_b,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             ld_a,
    output logic             ld_b,
    output logic             ovr
);
    logic       seq_b;
    logic [3:0] sub_q;
    logic       full_a, full_b;
    logic       hit, qual, last;

    assign hit  = seq_b ? edge_hit(ldb_edge, a_rise, a_fall)
                        : edge_hit(lda_edge, a_rise, a_fall);
    assign qual = run & ~trig & hit;
    assign last = (sub_q == sub_term(subs));
    assign ld_a = qual & last & ~seq_b;
    assign ld_b = qual & last & seq_b;
    assign ovr  = (ld_a & full_a) | (ld_b & full_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_b  <= 1'b0;
            sub_q  <= '0;
            full_a <= 1'b0;
            full_b <= 1'b0;
            cap_a  <= '0;
            cap_b  <= '0;
        end else begin
            if (trig) begin
                seq_b <= 1'b0;
                sub_q <= '0;
            end else if (qual) begin
                sub_q <= last ? 4'd0 : sub_q + 4'd1;
            end
            if (ld_a) begin
                cap_a <= cnt;
                seq_b <= (ldb_edge != EDG_NONE);
            end
            if (ld_b) begin
                cap_b <= cnt;
                seq_b <= 1'b0;
            end
            full_a <= ld_a | (full_a & ~rd_a);
            full_b <= ld_b | (full_b & ~rd_b);
        end
    end

    AST_CAPA_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> cap_a == $past(cnt)); // R7
    AST_CAPB_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> cap_b == $past(cnt)); // R7
    AST_SUB_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (ld_a || ld_b) |=> sub_q == 4'd0); // R8

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [3:0]      addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic [NSRC-1:0] clk_src,
    input  logic            in_a,
    input  logic            trig_in,
    output logic            irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cnt_q, top_q, cap_a, cap_b;
    logic             en_q, halt_q, tpend_q;
    logic [NFLAG-1:0] flags_q, mask_q, set_vec;
    logic             tick, run, step, at_top, at_max;
    logic [1:0]       e_rise, e_fall, e_lvl;
    logic             wr_cmd, wr_mode, wr_top, wr_ien, wr_idis;
    logic             rd_stat, rd_capa, rd_capb;
    logic             sw_trig, ext_trig, trig;
    logic             ld_a, ld_b, ovr;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;

    tcap_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (clk_src),
        .csel     (mode_q.clk_sel),
        .inv      (mode_q.clk_inv),
        .gate_sel (mode_q.gate_sel),
        .tick     (tick)
    );

    tcap_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({trig_in, in_a}),
        .rise (e_rise),
        .fall (e_fall),
        .lvl  (e_lvl)
    );

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign wr_mode = wr_en && (addr == A_MODE);
    assign wr_top  = wr_en && (addr == A_TOP);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign wr_idis = wr_en && (addr == A_IDIS);
    assign rd_stat = rd_en && (addr == A_STAT);
    assign rd_capa = rd_en && (addr == A_CAPA);
    assign rd_capb = rd_en && (addr == A_CAPB);

    assign sw_trig  = wr_cmd & wdata[2];
    assign ext_trig = mode_q.trig_src
                    ? edge_hit(mode_q.trig_edge, e_rise[1], e_fall[1])
                    : edge_hit(mode_q.trig_edge, e_rise[0], e_fall[0]);
    assign trig     = sw_trig | ext_trig;

    assign run    = en_q & ~halt_q;
    assign step   = tick & run;
    assign at_top = (cnt_q == top_q);
    assign at_max = &cnt_q;

    tcap_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .trig     (trig),
        .a_rise   (e_rise[0]),
        .a_fall   (e_fall[0]),
        .lda_edge (mode_q.lda_edge),
        .ldb_edge (mode_q.ldb_edge),
        .subs     (mode_q.subs),
        .cnt      (cnt_q),
        .rd_a     (rd_capa),
        .rd_b     (rd_capb),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .ld_a     (ld_a),
        .ld_b     (ld_b),
        .ovr      (ovr)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[F_OVF]  = step & ~tpend_q & at_max & ~(mode_q.top_rst & at_top);
        set_vec[F_LOVR] = ovr;
        set_vec[F_CMP]  = step & ~tpend_q & at_top;
        set_vec[F_LDA]  = ld_a;
        set_vec[F_LDB]  = ld_b;
        set_vec[F_ETRG] = ext_trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            cnt_q   <= '0;
            top_q   <= '0;
            en_q    <= 1'b0;
            halt_q  <= 1'b0;
            tpend_q <= 1'b0;
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            if (step) begin
                if (tpend_q || (mode_q.top_rst && at_top)) cnt_q <= '0;
                else                                       cnt_q <= cnt_q + 1'b1;
            end
            if (trig)      tpend_q <= 1'b1;
            else if (step) tpend_q <= 1'b0;

            if (trig)                        halt_q <= 1'b0;
            else if (ld_b && mode_q.stop_b)  halt_q <= 1'b1;

            if (wr_cmd && wdata[1])          en_q <= 1'b0;
            else if (wr_cmd && wdata[0])     en_q <= 1'b1;
            else if (ld_b && mode_q.dis_b)   en_q <= 1'b0;

            flags_q <= (rd_stat ? '0 : flags_q) | set_vec;

            if (wr_ien)       mask_q <= mask_q | wdata[NFLAG-1:0];
            else if (wr_idis) mask_q <= mask_q & ~wdata[NFLAG-1:0];

            if (wr_mode) mode_q <= mode_t'(wdata[MODE_W-1:0]);
            if (wr_top)  top_q  <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:  rdata = 32'(mode_q);
            A_CAPA:  rdata = 32'(cap_a);
            A_CAPB:  rdata = 32'(cap_b);
            A_CNT:   rdata = 32'(cnt_q);
            A_TOP:   rdata = 32'(top_q);
            A_STAT: begin
                rdata[NFLAG-1:0] = flags_q;
                rdata[ST_RUN]    = run;
                rdata[ST_MIRA]   = e_lvl[0];
                rdata[ST_MIRT]   = e_lvl[1];
            end
            A_IMASK: rdata = 32'(mask_q);
            default: rdata = '0;
        endcase
    end

    assign irq = |(flags_q & mask_q);

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q)); // R2
    AST_CNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (step && !tpend_q && !(mode_q.top_rst && at_top))
        |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wdata[0] && wdata[1]) |=> !en_q); // R3
    AST_TRIG_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (step && tpend_q) |=> cnt_q == '0); // R4
    AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ovr |=> flags_q[F_LOVR]); // R9
    AST_FREEZE_ON_B: assert property (@(posedge clk) disable iff (rst)
        (ld_b && mode_q.stop_b && !trig) |=> halt_q); // R10
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && set_vec == '0) |=> flags_q == '0); // R11
    AST_MASK_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_ien && wdata[0]) |=> mask_q[0]); // R12

endmodule

// File: tb/tcap_channel_tb_top.sv
`timescale 1ns/1ps
module tcap_channel_tb_top;

    localparam int CW   = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = 4'd4;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  clk_src = '0;
    logic        in_a = 1'b0, trig_in = 1'b0;
    logic        irq;

    int    vectors = 0, fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    int    ph = 0;
    logic [2:0] xg = '0;

    tcap_channel #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .clk_src(clk_src), .in_a(in_a),
        .trig_in(trig_in), .irq(irq)
    );

    always #2 clk = ~clk;

    // ---------------- behavioural reference ----------------
    int         m_cnt, m_top, m_capa, m_capb, m_sub, m_mask, m_flags, m_mode;
    bit         m_en, m_halt, m_tp, m_seq, m_afull, m_bfull, m_aq, m_tq;
    logic [7:0] m_srcq;

    function automatic bit hitf(int s, bit r, bit f);
        return (s == 1 && r) || (s == 2 && f) || (s == 3 && (r || f));
    endfunction

    function automatic int term(int c);
        return (c >= 4) ? 15 : (1 << c) - 1;
    endfunction

    function automatic logic [31:0] mread(logic [3:0] a);
        case (a)
            4'd1: return 32'(m_mode);
            4'd2: return 32'(m_capa);
            4'd3: return 32'(m_capb);
            4'd4: return 32'(m_cnt);
            4'd5: return 32'(m_top);
            4'd6: return 32'(m_flags) | (32'(m_en && !m_halt) << 8)
                       | (32'(m_aq) << 9) | (32'(m_tq) << 10);
            4'd9: return 32'(m_mask);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  csel, gsel, lda, ldb, subs, tedge, ncnt, nseq, nsub, setv;
        bit  inv, stopb, disb, tsrc, trst, tk, ar, af, tr, tf, cmd, sw, et, trg;
        bit  run, st, ntp, hq, la, lb, nh, ne;
        logic [7:0] rv, fv;
        if (rst) begin
            m_cnt = 0; m_top = 0; m_capa = 0; m_capb = 0; m_sub = 0; m_mask = 0;
            m_flags = 0; m_mode = 0; m_en = 0; m_halt = 0; m_tp = 0; m_seq = 0;
            m_afull = 0; m_bfull = 0; m_aq = 0; m_tq = 0; m_srcq = '0;
        end else begin
            csel = m_mode & 7;          inv   = m_mode[3];
            gsel = (m_mode >> 4) & 3;   lda   = (m_mode >> 6) & 3;
            ldb  = (m_mode >> 8) & 3;   subs  = (m_mode >> 10) & 7;
            stopb = m_mode[13];         disb  = m_mode[14];
            tedge = (m_mode >> 15) & 3; tsrc  = m_mode[17];
            trst  = m_mode[18];
            rv = clk_src & ~m_srcq; fv = ~clk_src & m_srcq;
            tk = (inv ? fv[csel] : rv[csel]) && (gsel == 0 || clk_src[4 + gsel]);
            ar = in_a && !m_aq;    af = !in_a && m_aq;
            tr = trig_in && !m_tq; tf = !trig_in && m_tq;
            cmd = wr_en && addr == 4'd0;
            sw  = cmd && wdata[2];
            et  = tsrc ? hitf(tedge, tr, tf) : hitf(tedge, ar, af);
            trg = sw || et;
            run = m_en && !m_halt;
            st  = tk && run;
            setv = 0; ncnt = m_cnt; ntp = m_tp;
            if (st) begin
                if (m_tp) begin ncnt = 0; ntp = 0; end
                else if (trst && m_cnt == m_top) begin ncnt = 0; setv |= 4; end
                else begin
                    if (m_cnt == m_top) setv |= 4;
                    if (m_cnt == MAXV)  setv |= 1;
                    ncnt = (m_cnt + 1) % (MAXV + 1);
                end
            end
            if (trg) ntp = 1;
            if (et) setv |= 32;
            la = 0; lb = 0; nseq = m_seq; nsub = m_sub;
            if (trg) begin nseq = 0; nsub = 0; end
            else if (run) begin
                hq = m_seq ? hitf(ldb, ar, af) : hitf(lda, ar, af);
                if (hq) begin
                    if (m_sub == term(subs)) begin
                        nsub = 0;
                        if (m_seq) lb = 1; else la = 1;
                    end else nsub = (m_sub + 1) % 16;
                end
            end
            if (la) begin
                if (m_afull) setv |= 2;
                setv |= 8; m_capa = m_cnt; nseq = (ldb != 0);
            end
            if (lb) begin
                if (m_bfull) setv |= 2;
                setv |= 16; m_capb = m_cnt; nseq = 0;
            end
            m_afull = la || (m_afull && !(rd_en && addr == 4'd2));
            m_bfull = lb || (m_bfull && !(rd_en && addr == 4'd3));
            if (trg) nh = 0; else if (lb && stopb) nh = 1; else nh = m_halt;
            if (cmd && wdata[1]) ne = 0;
            else if (cmd && wdata[0]) ne = 1;
            else if (lb && disb) ne = 0;
            else ne = m_en;
            m_flags = ((rd_en && addr == 4'd6) ? 0 : m_flags) | setv;
            if (wr_en && addr == 4'd7) m_mask = m_mask | (wdata & 63);
            if (wr_en && addr == 4'd8) m_mask = m_mask & ~(wdata & 63);
            if (wr_en && addr == 4'd1) m_mode = wdata & 32'h7FFFF;
            if (wr_en && addr == 4'd5) m_top = wdata & MAXV;
            m_cnt = ncnt; m_tp = ntp; m_seq = nseq; m_sub = nsub;
            m_halt = nh; m_en = ne;
            m_srcq = clk_src; m_aq = in_a; m_tq = trig_in;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        logic [31:0] er;
        bit ei;
        if (!rst && !done) begin
            vectors++;
            ei = (m_flags & m_mask) != 0;
            er = mread(addr);
            if (irq !== ei) begin
                fails++;
                $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, ei);
            end else if (rd_en && rdata !== er) begin
                fails++;
                $display("FAIL %s addr=%0d rdata actual=%h expected=%h",
                         cur_req, addr, rdata, er);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk); #1;
        ph = ph + 1;
        clk_src = {xg, 1'(ph >> 5), 4'(ph)};
        wr_en = 1'b0; rd_en = 1'b1; addr = 4'd4; wdata = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d; cyc();
    endtask

    task automatic rd(input logic [3:0] a);
        rd_en = 1'b1; addr = a; cyc();
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic pulse_a(input int n);
        repeat (n) begin
            in_a = 1'b1; idle(3);
            in_a = 1'b0; idle(3);
        end
    endtask

    function automatic logic [31:0] mk(int csel, int inv, int gsel, int lda, int ldb,
                                       int subs, int stopb, int disb, int tedge,
                                       int tsrc, int trst);
        return 32'((csel & 7) | ((inv & 1) << 3) | ((gsel & 3) << 4) | ((lda & 3) << 6)
                 | ((ldb & 3) << 8) | ((subs & 7) << 10) | ((stopb & 1) << 13)
                 | ((disb & 1) << 14) | ((tedge & 3) << 15) | ((tsrc & 1) << 17)
                 | ((trst & 1) << 18));
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; rd_en = 1'b1;

        cur_req = "R1";
        for (int a = 1; a < 10; a++) rd(4'(a));

        cur_req = "R2";
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h1);
        idle(20);
        wr(4'd1, mk(2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        idle(24);
        wr(4'd1, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        xg = 3'b000; idle(10);
        xg = 3'b001; idle(10);
        xg = 3'b000;

        cur_req = "R3";
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h3);
        idle(6); rd(4'd6);
        wr(4'd0, 32'h1);
        idle(4); rd(4'd6);

        cur_req = "R4";
        wr(4'd0, 32'h4);
        idle(6);
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0));
        trig_in = 1'b1; idle(5); trig_in = 1'b0; idle(5);
        rd(4'd6);
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0));
        in_a = 1'b1; idle(5); in_a = 1'b0; idle(5);
        rd(4'd6);

        cur_req = "R5";
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(4'd5, 32'd200);
        idle(560); rd(4'd6);

        cur_req = "R6";
        wr(4'd5, 32'd10);
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        idle(40); rd(4'd6);
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        idle(10); rd(4'd6);

        cur_req = "R7";
        wr(4'd5, 32'd250);
        wr(4'd1, mk(0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        pulse_a(3);
        rd(4'd2); rd(4'd3); rd(4'd6);
        wr(4'd1, mk(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        pulse_a(1); rd(4'd2);
        pulse_a(1); rd(4'd2); rd(4'd6);

        cur_req = "R8";
        wr(4'd1, mk(0, 0, 0, 1, 2, 1, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        pulse_a(5); rd(4'd2); rd(4'd3);
        wr(4'd1, mk(0, 0, 0, 3, 3, 2, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        pulse_a(6); rd(4'd2); rd(4'd3);
        wr(4'd1, mk(0, 0, 0, 1, 0, 5, 0, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        pulse_a(18); rd(4'd2); rd(4'd6);

        cur_req = "R9";
        wr(4'd1, mk(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        rd(4'd2); rd(4'd6);
        pulse_a(2); rd(4'd6);
        rd(4'd2); pulse_a(1); rd(4'd6);

        cur_req = "R10";
        wr(4'd1, mk(0, 0, 0, 1, 2, 0, 1, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        pulse_a(1);
        idle(10); rd(4'd6);
        wr(4'd0, 32'h4);
        idle(10); rd(4'd6);
        wr(4'd1, mk(0, 0, 0, 1, 2, 0, 0, 1, 0, 0, 0));
        pulse_a(1);
        idle(6); rd(4'd6);
        wr(4'd0, 32'h4);
        idle(6); rd(4'd6);
        wr(4'd0, 32'h1);
        idle(6);

        cur_req = "R11";
        rd(4'd6); rd(4'd6);
        in_a = 1'b1; rd(4'd6); rd(4'd6);
        wr(4'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0));
        in_a = 1'b0; rd(4'd6); rd(4'd6);

        cur_req = "R12";
        wr(4'd7, 32'h3F); rd(4'd9);
        wr(4'd1, mk(0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0));
        pulse_a(2); rd(4'd9);
        rd(4'd6); idle(3);
        wr(4'd8, 32'h37); rd(4'd9);
        pulse_a(2); rd(4'd6);
        wr(4'd8, 32'h3F); pulse_a(2); rd(4'd9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL %s watchdog expired", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule